// File: doc/BRIEF.md
# Strobe-Handshake Control Register Bank

This block holds a small set of 32-bit control/status registers behind a request/response handshake driven by strobes. A host-side adapter raises a request strobe together with a byte address, a direction flag, write data and a per-bit write mask. The block answers each accepted transfer with a one-cycle acknowledge on a channel reserved for reads or on a channel reserved for writes. Each acknowledge carries an error flag, and reads also return data.

The two directions have different latencies. A write is acknowledged in the same cycle it is accepted, because the acknowledge is combinational. A read is acknowledged one clock after acceptance, with its data registered. If a write arrived directly behind a read, its acknowledge would land in the same cycle as the read's. To prevent this, the block raises a stall that applies to writes only, for exactly the cycle in which a read acknowledge is due. The adapter must hold a stalled request unchanged until it is accepted. Reads never need holding, so the read stall stays low. This lets reads be issued back to back at full rate.

Top module: `strobe_regblock`

## Requirements
- R1: A synchronous active-low reset clears all four registers to zero and clears any pending read. In the first cycle after reset, rd_ack, wr_ack and stall_wr are low.
- R2: A write to a mapped address (byte offset 0x0, 0x4, 0x8 or 0xC) with stall_wr low is acknowledged by wr_ack high in the same cycle, with wr_err low.
- R3: A read accepted in cycle N gives rd_ack high in cycle N+1 only, with rd_data equal to the register value at acceptance and rd_err low for a mapped address.
- R4: On an accepted write, only the bit positions where wr_mask is 1 take the value of wr_data. All other bits of the addressed register keep their value.
- R5: stall_wr is high in exactly the cycle after a read was accepted. A write requested while stall_wr is high is neither acknowledged nor applied. The same write, held, is accepted in the next cycle in which stall_wr is low.
- R6: stall_rd is always low, so reads issued on consecutive cycles are each accepted and acknowledged on consecutive cycles.
- R7: rd_ack and wr_ack are never high in the same cycle, and acknowledges come back in request order.
- R8: A transfer to an unmapped or misaligned address completes with the normal timing, with the error flag of its direction set. For such a read, rd_data is zero. Such a write changes no register.
- R9: No acknowledge appears without a matching accepted request. With req low, wr_ack is low, and rd_ack is low unless a read was accepted in the cycle before.
- R10: An accepted read changes no register, whatever is driven on wr_data and wr_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe; qualifies req_addr, req_wr, wr_data, wr_mask |
| req_addr | input | 6 | Byte address of the transfer |
| req_wr | input | 1 | 1 = write, 0 = read |
| wr_data | input | 32 | Write data, ignored on reads |
| wr_mask | input | 32 | Active-high per-bit write enables |
| stall_rd | output | 1 | Holds back a pending read (always low here) |
| stall_wr | output | 1 | Holds back a pending write |
| rd_ack | output | 1 | One-cycle read completion strobe |
| rd_err | output | 1 | Read failed (valid with rd_ack) |
| rd_data | output | 32 | Read data (valid with rd_ack) |
| wr_ack | output | 1 | One-cycle write completion strobe |
| wr_err | output | 1 | Write failed (valid with wr_ack) |

## Verification
The bench targets a write issued right after a read. If the design omitted or mistimed the write stall, two acknowledges would appear in one cycle, or the held write would be applied twice or not at all. Partial-mask writes followed by readback would catch a design that ignores the mask or inverts its sense. Misaligned and out-of-range addresses would expose a decoder that aliases them onto a real register, returning stale data or corrupting a neighbour. Back-to-back reads, and reads carrying garbage write data, would catch a design that needlessly stalls reads or lets a read disturb storage.

// File: rtl/sbrb_pkg.sv
`timescale 1ns/1ps
// Package: shared transfer classification for the strobe register bank.
// Assumes one request per cycle, so a transfer is exactly one of these kinds.
package sbrb_pkg;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_RD   = 2'd1,
        XFER_WR   = 2'd2
    } xfer_e;

    // Classify the request lines into a transfer kind.
    function automatic xfer_e classify(input logic req, input logic is_wr);
        if (!req)  return XFER_NONE;
        if (is_wr) return XFER_WR;
        return XFER_RD;
    endfunction

endpackage

// File: rtl/sbrb_decode.sv
`timescale 1ns/1ps
// Module: sbrb_decode
// Turns a byte address into a one-hot register select and a hit flag.
// Assumes registers are DATA_W wide, packed at consecutive aligned offsets
// starting at zero. Misaligned or out-of-range addresses give hit = 0.
module sbrb_decode #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [NUM_REGS-1:0] sel
);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam int WORD_W  = ADDR_W - BYTE_SH;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;

    // Split the address into word index and byte offset.
    always_comb begin
        word_idx = addr[ADDR_W-1:BYTE_SH];
        aligned  = (addr[BYTE_SH-1:0] == '0);
    end

    // One select line per register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = aligned && (word_idx == WORD_W'(g));
    end

    // Hit if any register is selected.
    assign hit = |sel;
endmodule

// File: rtl/sbrb_regs.sv
`timescale 1ns/1ps
// Module: sbrb_regs
// Plain storage registers with per-bit masked writes and a one-hot read mux.
// Assumes sel is one-hot or zero and that wr_en is asserted only for an
// accepted write to a mapped address.
module sbrb_regs #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_REGS-1:0] sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W-1:0]   wr_mask,
    output logic [DATA_W-1:0]   rd_word
);
    logic [NUM_REGS-1:0][DATA_W-1:0] store_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Update enabled bits of this register on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[g] <= '0;
            end else if (wr_en && sel[g]) begin
                store_q[g] <= (store_q[g] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    // OR together the selected register; zero when nothing is selected.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rd_word = rd_word | store_q[i];
        end
    end
endmodule

// File: rtl/sbrb_resp.sv
`timescale 1ns/1ps
// Module: sbrb_resp
// Registers the read response and tracks the read in flight.
// Assumes a read is acknowledged exactly one cycle after acceptance; the
// in-flight flag doubles as the write stall so a same-cycle write ack
// cannot collide with the read ack.
module sbrb_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_busy,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data
);
    logic              pend_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;

    // Capture the response of an accepted read for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            pend_q <= rd_accept;
            err_q  <= rd_accept && !rd_hit;
            data_q <= (rd_accept && rd_hit) ? rd_word : '0;
        end
    end

    // Drive the response outputs from the captured state.
    always_comb begin
        rd_busy = pend_q;
        rd_ack  = pend_q;
        rd_err  = pend_q && err_q;
        rd_data = pend_q ? data_q : '0;
    end
endmodule

// File: rtl/strobe_regblock.sv
`timescale 1ns/1ps
// Module: strobe_regblock
// Register bank behind a strobe request/response handshake. Writes are
// acknowledged in the cycle they are accepted, reads one cycle later. A
// write is stalled while a read ack is due, which keeps acks ordered and
// never simultaneous. Assumes the requester holds a stalled request stable.
module strobe_regblock #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    output logic              stall_rd,
    output logic              stall_wr,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              wr_err
);
    import sbrb_pkg::*;

    xfer_e               kind;
    logic                hit;
    logic [NUM_REGS-1:0] sel;
    logic [DATA_W-1:0]   rd_word;
    logic                rd_busy;
    logic                rd_accept;
    logic                wr_accept;

    sbrb_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) decode_i (
        .addr(req_addr),
        .hit (hit),
        .sel (sel)
    );

    // Decide which transfer, if any, is accepted this cycle.
    always_comb begin
        kind      = classify(req, req_wr);
        stall_rd  = 1'b0;
        stall_wr  = rd_busy;
        rd_accept = (kind == XFER_RD) && !stall_rd;
        wr_accept = (kind == XFER_WR) && !stall_wr;
    end

    sbrb_regs #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_accept && hit),
        .sel    (sel),
        .wr_data(wr_data),
        .wr_mask(wr_mask),
        .rd_word(rd_word)
    );

    sbrb_resp #(
        .DATA_W(DATA_W)
    ) resp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_accept(rd_accept),
        .rd_hit   (hit),
        .rd_word  (rd_word),
        .rd_busy  (rd_busy),
        .rd_ack   (rd_ack),
        .rd_err   (rd_err),
        .rd_data  (rd_data)
    );

    // Zero-latency write response.
    always_comb begin
        wr_ack = wr_accept;
        wr_err = wr_accept && !hit;
    end
endmodule

// File: rtl/sbrb_chk.sv
`timescale 1ns/1ps
// Module: sbrb_chk
// Protocol checks on the ports of strobe_regblock, attached by bind.
module sbrb_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              req_wr,
    input logic              stall_rd,
    input logic              stall_wr,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_ack,
    input logic              wr_err
);
    // R7
    one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && wr_ack));

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_wr && !stall_rd) |=> rd_ack);

    // R9
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(req && !req_wr));

    // R5
    wr_stall_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_wr && !stall_rd) |=> stall_wr);

    // R5
    no_wack_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_wr |-> !wr_ack);

    // R2
    wr_ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (req && req_wr));

    // R6
    rd_never_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_rd);

    // R8
    err_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_err) |-> (rd_data == '0));

    // R8
    wr_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> wr_ack);
endmodule

bind strobe_regblock sbrb_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .req_wr  (req_wr),
    .stall_rd(stall_rd),
    .stall_wr(stall_wr),
    .rd_ack  (rd_ack),
    .rd_err  (rd_err),
    .rd_data (rd_data),
    .wr_ack  (wr_ack),
    .wr_err  (wr_err)
);

// File: tb/strobe_regblock_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (array + response queue) compared
// against the block on every clock.
module strobe_regblock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [5:0]  req_addr = '0;
    logic        req_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic        stall_rd, stall_wr, rd_ack, rd_err, wr_ack, wr_err;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } rsp_t;

    logic [31:0] mdl [4];
    rsp_t        rq [$];

    always #10 clk = ~clk;

    strobe_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_wr(req_wr), .wr_data(wr_data), .wr_mask(wr_mask),
        .stall_rd(stall_rd), .stall_wr(stall_wr), .rd_ack(rd_ack),
        .rd_err(rd_err), .rd_data(rd_data), .wr_ack(wr_ack), .wr_err(wr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mapped(input logic [5:0] a);
        return (a[1:0] == 2'b00) && (a[5:2] < 4);
    endfunction

    // One clock of stimulus plus comparison; acc reports acceptance.
    task automatic step(input logic r, input logic [5:0] a, input logic w,
                        input logic [31:0] d, input logic [31:0] m,
                        input string tag, output bit acc);
        bit   pend, exp_wack;
        rsp_t e;
        @(negedge clk);
        req = r; req_addr = a; req_wr = w; wr_data = d; wr_mask = m;
        #5;
        pend = (rq.size() > 0);
        check("R5", {31'd0, stall_wr}, {31'd0, pend});
        check("R6", {31'd0, stall_rd}, 32'd0);
        check("R9", {31'd0, rd_ack}, {31'd0, pend});
        check("R7", {31'd0, rd_ack && wr_ack}, 32'd0);
        if (pend) begin
            e = rq.pop_front();
            check(e.tag, rd_data, e.data);
            check("R8", {31'd0, rd_err}, {31'd0, e.err});
        end
        exp_wack = r && w && !pend;
        check(w ? tag : "R9", {31'd0, wr_ack}, {31'd0, exp_wack});
        check("R8", {31'd0, wr_err}, {31'd0, exp_wack && !mapped(a)});
        acc = r && (!w || !pend);
        if (r && !w) begin
            e.data = mapped(a) ? mdl[a[3:2]] : 32'd0;
            e.err  = !mapped(a);
            e.tag  = tag;
            rq.push_back(e);
        end
        if (exp_wack && mapped(a))
            mdl[a[3:2]] = (mdl[a[3:2]] & ~m) | (d & m);
    endtask

    // Issue a request and hold it until accepted.
    task automatic xfer(input logic [5:0] a, input logic w, input logic [31:0] d,
                        input logic [31:0] m, input string tag);
        bit acc = 1'b0;
        while (!acc) step(1'b1, a, w, d, m, tag, acc);
    endtask

    task automatic idle(input string tag);
        bit acc;
        step(1'b0, 6'h0, 1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, tag, acc);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit acc;
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet after reset
        check("R1", {31'd0, rd_ack}, 32'd0);
        check("R1", {31'd0, wr_ack}, 32'd0);
        check("R1", {31'd0, stall_wr}, 32'd0);
        rst_n = 1'b1;

        // R1, R6: back-to-back reads of every register return zero
        for (int i = 0; i < 4; i++) xfer(6'(i * 4), 1'b0, '0, '0, "R1");
        idle("R9");

        // R2: full-mask writes, then readback
        xfer(6'h0, 1'b1, 32'h1111_2222, 32'hFFFF_FFFF, "R2");
        xfer(6'h4, 1'b1, 32'hA5A5_5A5A, 32'hFFFF_FFFF, "R2");
        xfer(6'h8, 1'b1, 32'h0F0F_F0F0, 32'hFFFF_FFFF, "R2");
        xfer(6'hC, 1'b1, 32'hCAFE_F00D, 32'hFFFF_FFFF, "R2");
        for (int i = 0; i < 4; i++) xfer(6'(i * 4), 1'b0, '0, '0, "R3");

        // R4: partial masks
        xfer(6'h4, 1'b1, 32'hFFFF_FFFF, 32'h0000_FF00, "R4");
        xfer(6'h4, 1'b0, '0, '0, "R4");
        xfer(6'h8, 1'b1, 32'h0000_0000, 32'hF000_000F, "R4");
        xfer(6'h8, 1'b0, '0, '0, "R4");
        xfer(6'hC, 1'b1, 32'h1234_5678, 32'h0000_0000, "R4");
        xfer(6'hC, 1'b0, '0, '0, "R4");

        // R5: write right behind a read is held one cycle
        xfer(6'h0, 1'b0, '0, '0, "R5");
        xfer(6'h0, 1'b1, 32'h7777_0000, 32'hFFFF_0000, "R5");
        xfer(6'h0, 1'b0, '0, '0, "R5");
        idle("R9");

        // R8: unmapped and misaligned addresses
        xfer(6'h10, 1'b0, '0, '0, "R8");
        xfer(6'h3C, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
        xfer(6'h02, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
        xfer(6'h05, 1'b0, '0, '0, "R8");
        for (int i = 0; i < 4; i++) xfer(6'(i * 4), 1'b0, '0, '0, "R8");

        // R10: reads carrying write data do not disturb storage
        xfer(6'h4, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        xfer(6'h4, 1'b0, '0, '0, "R10");
        idle("R9");
        idle("R9");

        // R7: random mix, acks checked for order and exclusivity
        for (int n = 0; n < 400; n++) begin
            logic [5:0] a;
            a = ($urandom % 5 == 0) ? 6'($urandom) : 6'(($urandom % 4) * 4);
            if ($urandom % 4 == 0) idle("R9");
            else xfer(a, 1'($urandom), $urandom, $urandom, "R7");
        end
        idle("R9");
        idle("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule